// File: doc/BRIEF.md
# Tape Character Transfer Timing Sequencer

This block produces every timed pulse needed to move one character between a host interface and an incremental-write, continuous-read tape transport. It replaces analog one-shot circuits with clock-cycle counters. All intervals are given as parameters in nanoseconds and are turned into cycle counts from the clock frequency.

In write mode, a data-out strobe from the host starts a chain of timed phases. First comes a write-step pulse to the transport. A settle interval follows, so that the transport's echo-parity error pulse, which can arrive late, falls inside a short sample window; any error seen there sets a sticky flag. Two long gap intervals then keep successive steps below the transport's maximum rate of 300 characters per second. A one-cycle-class completion pulse ends the sequence and sets the done flag.

In read mode, the leading edge of the transport's character clock is delayed by a short interval. A load strobe then captures the input register while its data is still valid, and the same strobe sets done. An I/O reset input cancels whatever is running.

Top module: `tape_step_seq`

At the default parameters (1 MHz clock), the phase lengths in cycles are: step 40, settle 20, sample 2, each gap 2000, completion 1, read delay 1, read load 1. In the requirements, "A" means the rising clock edge at which a data-out strobe is accepted, and "E" means the first edge at which the character clock is seen high after being low.

## Requirements
- R1: An accepted `data_out_stb` (block idle, `io_reset` low) drives `write_step` high for exactly STEP cycles, from edge A to edge A+STEP. `busy` is high from edge A until the completion pulse ends.
- R2: `parity_sample` is high for SAMPLE cycles. It rises STEP+SETTLE cycles after `write_step` rises, which places it 60 to 75 µs after the step's leading edge.
- R3: `parity_err_flag` is set if `parity_err_in` is high at any edge at which the sample window is open. With the default (any-cycle) capture variant, a pulse of `parity_err_in` that lies wholly outside the window leaves the flag low.
- R4: `parity_err_flag` is cleared when the next write step is accepted and holds its value until then.
- R5: `done_pulse` is high for FIN cycles, starting STEP+SETTLE+SAMPLE+2·GAP cycles after `write_step` rises. `done` is high from the edge that follows the start of `done_pulse`, and `busy` is low from the edge that ends `done_pulse`.
- R6: A `data_out_stb` seen while `busy` is high, including during the completion pulse, starts nothing and sets the sticky `overrun` flag. Only `io_reset` clears `overrun`.
- R7: A rising edge of `char_clk` in read-idle state raises `load_in_stb` and `done_pulse` for RD_LOAD cycles, starting RD_DELAY cycles after edge E. `done` is set by that strobe.
- R8: A new rising edge of `char_clk` while a read delay or load is still running is ignored, and a `char_clk` held high does not retrigger.
- R9: `io_reset` returns both sequences to idle at the next edge without a completion pulse. It also clears `done`, `overrun` and `parity_err_flag`.
- R10: `done` is cleared at the edge where a new write or read sequence is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_reset | input | 1 | Synchronous abort of all sequences |
| data_out_stb | input | 1 | Host strobe that starts a write step |
| parity_err_in | input | 1 | Echo-parity error pulse from the transport |
| char_clk | input | 1 | Read character clock from the transport |
| write_step | output | 1 | Write-step pulse to the transport |
| parity_sample | output | 1 | Window in which the error line is sampled |
| parity_err_flag | output | 1 | Sticky parity-error status |
| load_in_stb | output | 1 | Strobe that loads the input data register |
| done_pulse | output | 1 | Completion pulse (write or read) |
| done | output | 1 | Done status flag |
| busy | output | 1 | Write sequence in progress |
| overrun | output | 1 | A strobe arrived during a write sequence |

## Verification
Two events can fall in the same cycle: the completion pulse of one write, and the host's strobe for the next character. A directed run raises `data_out_stb` exactly in the cycle of `done_pulse`. The run passes only if `done` still gets set, `overrun` gets set, and no second `write_step` appears. Random runs place the error pulse at random offsets around the two-cycle sample window, and put stray strobes at random points of the busy span. The expected flags are computed from the window bounds.

// File: rtl/tss_pkg.sv
package tss_pkg;

   typedef enum logic [2:0] {
      WS_IDLE, WS_STEP, WS_SETTLE, WS_SAMPLE, WS_GAP1, WS_GAP2, WS_FIN
   } wr_state_t;

   typedef enum logic [1:0] {
      RS_IDLE, RS_WAIT, RS_LOAD
   } rd_state_t;

   // Round a duration up to whole clock cycles.
   function automatic int to_cyc(longint hz, longint ns);
      return int'((hz * ns + 64'd999_999_999) / 64'd1_000_000_000);
   endfunction

   function automatic int max_i(int a, int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/tss_timer.sv
module tss_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (clr)        cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/tss_write_fsm.sv
module tss_write_fsm
   import tss_pkg::*;
#(
   parameter int CW           = 11,
   parameter int STEP_C       = 40,
   parameter int SETTLE_C     = 20,
   parameter int SAMPLE_C     = 2,
   parameter int GAP_C        = 2000,
   parameter int FIN_C        = 1,
   parameter bit LATCH_AT_END = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic abort,
   input  logic start_req,
   input  logic parity_err_in,
   output logic step,
   output logic sample_win,
   output logic err_flag,
   output logic fin,
   output logic busy,
   output logic accept
);
   wr_state_t     st, st_nx;
   logic          ld, tm_zero;
   logic [CW-1:0] lv;
   logic          cap_en, cap_val;

   function automatic wr_state_t succ(wr_state_t s);
      case (s)
         WS_STEP:   return WS_SETTLE;
         WS_SETTLE: return WS_SAMPLE;
         WS_SAMPLE: return WS_GAP1;
         WS_GAP1:   return WS_GAP2;
         WS_GAP2:   return WS_FIN;
         default:   return WS_IDLE;
      endcase
   endfunction

   function automatic logic [CW-1:0] len_of(wr_state_t s);
      case (s)
         WS_STEP:   return CW'(STEP_C - 1);
         WS_SETTLE: return CW'(SETTLE_C - 1);
         WS_SAMPLE: return CW'(SAMPLE_C - 1);
         WS_GAP1,
         WS_GAP2:   return CW'(GAP_C - 1);
         WS_FIN:    return CW'(FIN_C - 1);
         default:   return '0;
      endcase
   endfunction

   always_comb begin
      st_nx  = st;
      ld     = 1'b0;
      accept = 1'b0;
      if (st == WS_IDLE) begin
         if (start_req && !abort) begin
            accept = 1'b1;
            st_nx  = WS_STEP;
            ld     = 1'b1;
         end
      end else if (tm_zero) begin
         st_nx = succ(st);
         ld    = (st_nx != WS_IDLE);
      end
      lv = len_of(st_nx);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     st <= WS_IDLE;
      else if (abort) st <= WS_IDLE;
      else            st <= st_nx;
   end

   tss_timer #(.CW(CW)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (abort),
      .load     (ld),
      .load_val (lv),
      .expired  (tm_zero)
   );

   generate
      if (LATCH_AT_END) begin : g_cap_end
         assign cap_en  = (st == WS_SAMPLE) && tm_zero;
         assign cap_val = parity_err_in;
      end else begin : g_cap_any
         assign cap_en  = (st == WS_SAMPLE) && parity_err_in;
         assign cap_val = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      err_flag <= 1'b0;
      else if (abort)  err_flag <= 1'b0;
      else if (accept) err_flag <= 1'b0;
      else if (cap_en) err_flag <= cap_val;
   end

   assign step       = (st == WS_STEP);
   assign sample_win = (st == WS_SAMPLE);
   assign fin        = (st == WS_FIN);
   assign busy       = (st != WS_IDLE);
endmodule

// File: rtl/tss_read_fsm.sv
module tss_read_fsm
   import tss_pkg::*;
#(
   parameter int CW     = 11,
   parameter int RD_C   = 1,
   parameter int LOAD_C = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic abort,
   input  logic char_clk,
   output logic load_stb,
   output logic accept
);
   rd_state_t     st, st_nx;
   logic          clk_q, rise, ld, tm_zero;
   logic [CW-1:0] lv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clk_q <= 1'b0;
      else        clk_q <= char_clk;
   end

   assign rise = char_clk && !clk_q;

   always_comb begin
      st_nx  = st;
      ld     = 1'b0;
      accept = 1'b0;
      lv     = '0;
      case (st)
         RS_IDLE: if (rise && !abort) begin
            accept = 1'b1;
            st_nx  = RS_WAIT;
            ld     = 1'b1;
            lv     = CW'(RD_C - 1);
         end
         RS_WAIT: if (tm_zero) begin
            st_nx = RS_LOAD;
            ld    = 1'b1;
            lv    = CW'(LOAD_C - 1);
         end
         default: if (tm_zero) st_nx = RS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     st <= RS_IDLE;
      else if (abort) st <= RS_IDLE;
      else            st <= st_nx;
   end

   tss_timer #(.CW(CW)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (abort),
      .load     (ld),
      .load_val (lv),
      .expired  (tm_zero)
   );

   assign load_stb = (st == RS_LOAD);
endmodule

// File: rtl/tape_step_seq.sv
module tape_step_seq
   import tss_pkg::*;
#(
   parameter longint CLK_HZ        = 1_000_000,
   parameter longint STEP_NS       = 40_000,
   parameter longint SETTLE_NS     = 20_000,
   parameter longint SAMPLE_NS     = 2_000,
   parameter longint GAP_NS        = 2_000_000,
   parameter longint FIN_NS        = 1_000,
   parameter longint RD_DELAY_NS   = 1_000,
   parameter longint RD_LOAD_NS    = 1_000,
   parameter longint MAX_CPS       = 300,
   parameter longint PROBE_MIN_NS  = 60_000,
   parameter longint PROBE_MAX_NS  = 75_000,
   parameter longint DATA_VALID_NS = 20_000,
   parameter bit     SAMPLE_AT_END = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic io_reset,
   input  logic data_out_stb,
   input  logic parity_err_in,
   input  logic char_clk,
   output logic write_step,
   output logic parity_sample,
   output logic parity_err_flag,
   output logic load_in_stb,
   output logic done_pulse,
   output logic done,
   output logic busy,
   output logic overrun
);
   localparam int STEP_C     = to_cyc(CLK_HZ, STEP_NS);
   localparam int SETTLE_C   = to_cyc(CLK_HZ, SETTLE_NS);
   localparam int SAMPLE_C   = to_cyc(CLK_HZ, SAMPLE_NS);
   localparam int GAP_C      = to_cyc(CLK_HZ, GAP_NS);
   localparam int FIN_C      = to_cyc(CLK_HZ, FIN_NS);
   localparam int RD_C       = to_cyc(CLK_HZ, RD_DELAY_NS);
   localparam int LOAD_C     = to_cyc(CLK_HZ, RD_LOAD_NS);
   localparam int SPACING_C  = to_cyc(CLK_HZ, 64'd1_000_000_000 / MAX_CPS);
   localparam int PROBE_LO_C = to_cyc(CLK_HZ, PROBE_MIN_NS);
   localparam int PROBE_HI_C = to_cyc(CLK_HZ, PROBE_MAX_NS);
   localparam int VALID_C    = to_cyc(CLK_HZ, DATA_VALID_NS);
   localparam int SEQ_C      = STEP_C + SETTLE_C + SAMPLE_C + 2 * GAP_C + FIN_C;
   localparam int MAXLEN     = max_i(max_i(max_i(STEP_C, SETTLE_C), max_i(SAMPLE_C, GAP_C)),
                                     max_i(FIN_C, max_i(RD_C, LOAD_C)));
   localparam int CW         = $clog2(MAXLEN + 1);

   generate
      if (STEP_C < 1 || SETTLE_C < 1 || SAMPLE_C < 1 || GAP_C < 1 ||
          FIN_C < 1 || RD_C < 1 || LOAD_C < 1) begin : g_bad_len
         $error("every interval must last at least one clock cycle");
      end
      if (SEQ_C < SPACING_C) begin : g_bad_rate
         $error("write sequence shorter than the minimum step spacing");
      end
      if (STEP_C + SETTLE_C < PROBE_LO_C || STEP_C + SETTLE_C > PROBE_HI_C) begin : g_bad_probe
         $error("parity sample point outside its allowed window");
      end
      if (RD_C + LOAD_C > VALID_C) begin : g_bad_read
         $error("read load strobe ends after input data becomes invalid");
      end
   endgenerate

   logic wr_fin, wr_accept, rd_accept;

   tss_write_fsm #(
      .CW (CW), .STEP_C (STEP_C), .SETTLE_C (SETTLE_C), .SAMPLE_C (SAMPLE_C),
      .GAP_C (GAP_C), .FIN_C (FIN_C), .LATCH_AT_END (SAMPLE_AT_END)
   ) u_wr (
      .clk           (clk),
      .rst_n         (rst_n),
      .abort         (io_reset),
      .start_req     (data_out_stb),
      .parity_err_in (parity_err_in),
      .step          (write_step),
      .sample_win    (parity_sample),
      .err_flag      (parity_err_flag),
      .fin           (wr_fin),
      .busy          (busy),
      .accept        (wr_accept)
   );

   tss_read_fsm #(.CW (CW), .RD_C (RD_C), .LOAD_C (LOAD_C)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .abort    (io_reset),
      .char_clk (char_clk),
      .load_stb (load_in_stb),
      .accept   (rd_accept)
   );

   assign done_pulse = wr_fin || load_in_stb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      done <= 1'b0;
      else if (io_reset)               done <= 1'b0;
      else if (done_pulse)             done <= 1'b1;
      else if (wr_accept || rd_accept) done <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     overrun <= 1'b0;
      else if (io_reset)              overrun <= 1'b0;
      else if (data_out_stb && busy)  overrun <= 1'b1;
   end
endmodule

// File: rtl/tss_checker.sv
module tss_checker #(
   parameter int PROBE_C = 60
) (
   input logic clk,
   input logic rst_n,
   input logic io_reset,
   input logic data_out_stb,
   input logic write_step,
   input logic parity_sample,
   input logic parity_err_flag,
   input logic load_in_stb,
   input logic done_pulse,
   input logic done,
   input logic busy,
   input logic overrun
);
   logic        ws_q;
   int unsigned since_step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ws_q       <= 1'b0;
         since_step <= 0;
      end else begin
         ws_q <= write_step;
         if (write_step && !ws_q)     since_step <= 1;
         else if (since_step != 0 && since_step != 32'hFFFF_FFFF)
                                      since_step <= since_step + 1;
      end
   end

   AST_STEP_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(write_step) |-> ($past(data_out_stb) && !$past(busy) && !$past(io_reset))); // R1
   AST_SAMPLE_POINT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(parity_sample) |-> (since_step == PROBE_C)); // R2
   AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(write_step) |-> !parity_err_flag); // R4
   AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (done_pulse && !io_reset) |=> done); // R5
   AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (data_out_stb && busy && !io_reset) |=> (overrun && !$rose(write_step))); // R6
   AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      io_reset |=> (!write_step && !done_pulse && !busy && !load_in_stb && !done)); // R9
endmodule

bind tape_step_seq tss_checker #(.PROBE_C (STEP_C + SETTLE_C)) u_tss_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .io_reset        (io_reset),
   .data_out_stb    (data_out_stb),
   .write_step      (write_step),
   .parity_sample   (parity_sample),
   .parity_err_flag (parity_err_flag),
   .load_in_stb     (load_in_stb),
   .done_pulse      (done_pulse),
   .done            (done),
   .busy            (busy),
   .overrun         (overrun)
);

// File: tb/tape_step_seq_test.sv
`timescale 1ns/1ps
module tape_step_seq_test;
   localparam int CLK_PERIOD = 1000;
   localparam int STEP_C = 40, SETTLE_C = 20, SAMPLE_C = 2, GAP_C = 2000;
   localparam int PROBE = STEP_C + SETTLE_C;
   localparam int TOT   = STEP_C + SETTLE_C + SAMPLE_C + 2 * GAP_C;

   logic clk = 1'b0, rst_n = 1'b0, io_reset = 1'b0, data_out_stb = 1'b0;
   logic parity_err_in = 1'b0, char_clk = 1'b0;
   logic write_step, parity_sample, parity_err_flag, load_in_stb;
   logic done_pulse, done, busy, overrun;
   int   n_checks = 0, n_fail = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   tape_step_seq uut (
      .clk (clk), .rst_n (rst_n), .io_reset (io_reset), .data_out_stb (data_out_stb),
      .parity_err_in (parity_err_in), .char_clk (char_clk), .write_step (write_step),
      .parity_sample (parity_sample), .parity_err_flag (parity_err_flag),
      .load_in_stb (load_in_stb), .done_pulse (done_pulse), .done (done),
      .busy (busy), .overrun (overrun)
   );

   // k counts falling edges after the accepting edge
   function automatic bit e_step(int k);   return k >= 1 && k <= STEP_C; endfunction
   function automatic bit e_sample(int k); return k >= PROBE + 1 && k <= PROBE + SAMPLE_C; endfunction
   function automatic bit e_fin(int k);    return k == TOT + 1; endfunction
   function automatic bit e_busy(int k);   return k >= 1 && k <= TOT + 1; endfunction
   function automatic bit e_flag(int off, int len);
      return len > 0 && off <= PROBE + SAMPLE_C && off + len - 1 >= PROBE + 1;
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   task automatic io_pulse();
      @(negedge clk) io_reset = 1'b1;
      @(negedge clk) io_reset = 1'b0;
      chk(overrun == 1'b0, "R6 overrun cleared by io_reset", int'(overrun), 0);
      chk(done == 1'b0, "R9 done cleared by io_reset", int'(done), 0);
   endtask

   task automatic write_run(int off, int len, int xs, bit chk_clear);
      int bk[4]; int ba[4]; int be[4];
      bit exp_ov;
      for (int i = 0; i < 4; i++) bk[i] = -1;
      exp_ov = (xs >= 1 && xs <= TOT + 1);
      @(negedge clk) data_out_stb = 1'b1;
      for (int k = 1; k <= TOT + 2; k++) begin
         @(negedge clk);
         data_out_stb  = (k == xs);
         parity_err_in = (len > 0 && k >= off && k < off + len);
         if (write_step !== e_step(k) && bk[0] < 0)      begin bk[0] = k; ba[0] = int'(write_step);    be[0] = int'(e_step(k));   end
         if (parity_sample !== e_sample(k) && bk[1] < 0) begin bk[1] = k; ba[1] = int'(parity_sample); be[1] = int'(e_sample(k)); end
         if (done_pulse !== e_fin(k) && bk[2] < 0)       begin bk[2] = k; ba[2] = int'(done_pulse);    be[2] = int'(e_fin(k));    end
         if (busy !== e_busy(k) && bk[3] < 0)            begin bk[3] = k; ba[3] = int'(busy);          be[3] = int'(e_busy(k));   end
         if (k == 1 && chk_clear) begin
            chk(done == 1'b0, "R10 done cleared on write accept", int'(done), 0);
            chk(parity_err_flag == 1'b0, "R4 flag cleared on new step", int'(parity_err_flag), 0);
         end
      end
      data_out_stb  = 1'b0;
      parity_err_in = 1'b0;
      chk(bk[0] < 0, "R1 write_step timing", ba[0], be[0]);
      chk(bk[1] < 0, "R2 parity_sample timing", ba[1], be[1]);
      chk(bk[2] < 0, "R5 done_pulse timing", ba[2], be[2]);
      chk(bk[3] < 0, "R1 busy span", ba[3], be[3]);
      chk(done == 1'b1, "R5 done set after completion", int'(done), 1);
      chk(parity_err_flag == e_flag(off, len), "R3 parity flag capture",
          int'(parity_err_flag), int'(e_flag(off, len)));
      chk(overrun == exp_ov, "R6 overrun on busy strobe", int'(overrun), int'(exp_ov));
   endtask

   task automatic abort_run(int ab);
      int bad_k = -1;
      @(negedge clk) data_out_stb = 1'b1;
      for (int k = 1; k <= TOT + 8; k++) begin
         @(negedge clk);
         data_out_stb = 1'b0;
         io_reset     = (k == ab);
         if (k > ab && (write_step || done_pulse || busy || parity_sample) && bad_k < 0) bad_k = k;
      end
      io_reset = 1'b0;
      chk(bad_k < 0, "R9 quiet after abort", bad_k, -1);
      chk(done == 1'b0, "R9 no done after abort", int'(done), 0);
   endtask

   task automatic read_run(int hi, bit rt, bit chk_clear);
      int bad_k = -1; int bad_v = 0;
      @(negedge clk) char_clk = 1'b1;
      for (int k = 1; k <= 25; k++) begin
         @(negedge clk);
         char_clk = rt ? (k == 2 || k == 3) : (k < hi);
         if ((load_in_stb !== (k == 2) || done_pulse !== (k == 2)) && bad_k < 0) begin
            bad_k = k; bad_v = int'(load_in_stb);
         end
         if (k == 1 && chk_clear)
            chk(done == 1'b0, "R10 done cleared on read accept", int'(done), 0);
      end
      char_clk = 1'b0;
      chk(bad_k < 0, rt ? "R8 no retrigger during read" : "R7 load strobe timing", bad_v, int'(bad_k == 2));
      chk(done == 1'b1, "R7 done set by load strobe", int'(done), 1);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
   end

   initial begin
      void'($urandom(32'h0005_EED5));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk({write_step, parity_sample, parity_err_flag, load_in_stb, done_pulse, done, busy, overrun} == 8'd0,
          "R1 reset state", int'({write_step, parity_sample, done, busy}), 0);

      // directed: error pulse covering the sample window
      write_run(PROBE + 1, 15, 0, 1'b0);
      // directed: strobe in the completion cycle (same-cycle case)
      write_run(0, 0, TOT + 1, 1'b1);
      io_pulse();
      // directed: error pulse ending one cycle before the window
      write_run(PROBE - 15, 15, 0, 1'b0);
      io_pulse();
      // random writes
      for (int r = 0; r < 4; r++) begin
         int off, len, xs;
         off = int'($urandom_range(40, 80));
         len = int'($urandom_range(1, 15));
         xs  = ($urandom_range(0, 1) == 0) ? 0 : int'($urandom_range(1, TOT + 1));
         write_run(off, len, xs, 1'b0);
         io_pulse();
      end
      // aborts: in the completion cycle and at a random point
      abort_run(TOT + 1);
      abort_run(int'($urandom_range(1, TOT)));
      // reads
      write_run(0, 0, 0, 1'b0);
      read_run(20, 1'b0, 1'b1);
      read_run(1, 1'b1, 1'b0);
      for (int r = 0; r < 6; r++)
         read_run(int'($urandom_range(1, 20)), 1'($urandom_range(0, 1)), 1'b0);
      summary();
   end
endmodule